// File: doc/BRIEF.md
# DRAM Refresh Request Generator

This block keeps dynamic memory refreshed by raising a DMA request on the channel reserved for refresh. No other traffic uses that channel. A prescaler divides the system clock down to a fixed refresh interval of 15 µs by default. Each interval ends with a one-cycle tick, and the tick sets a request flip-flop that drives the channel request output.

The DMA controller answers with an acknowledge on the same channel. While the acknowledge is high, the block reports that the memory cycle in progress is a refresh cycle. The acknowledge also clears the pending request. An 8-bit row counter supplies the row to refresh. It advances by one each time the acknowledge is released, so successive refresh cycles walk through all 256 rows.

A sticky overrun flag records that a new interval expired while the previous request was still waiting for service.

Top module: `refresh_req_gen`

## Requirements
- R1: The first request asserts exactly N clock edges after reset is released, where N = round(CLK_HZ × PERIOD_NS / 1e9), rounded to the nearest whole cycle with halves rounding up. Further ticks follow every N edges.
- R2: A tick sets `dma_req_o`. The request then stays high until a clock edge at which `refresh_ack_i` is high, and that edge clears it. If a tick and an acknowledge fall on the same edge, the tick wins and the request stays high.
- R3: `refresh_o` follows `refresh_ack_i` combinationally, in the same cycle.
- R4: `row_addr_o` increments by one at the first clock edge where the acknowledge is low after having been high at the previous edge. An acknowledge held high for several cycles counts once.
- R5: The row address wraps from 255 to 0.
- R6: `overrun_o` sets when a tick arrives while the request is pending and the acknowledge is low. It then stays set until reset.
- R7: Synchronous active-high reset clears the request, the row address and the overrun flag, and restarts the interval count from zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| refresh_ack_i | input | 1 | DMA acknowledge for the refresh channel, active high |
| dma_req_o | output | 1 | DMA request for the refresh channel |
| refresh_o | output | 1 | High while the current memory cycle is a refresh cycle |
| row_addr_o | output | 8 | Row address for the refresh cycle |
| overrun_o | output | 1 | Sticky flag: an interval expired with a request still pending |

## Verification
The assertions check on every cycle that:
- the refresh indication mirrors the acknowledge;
- a pending request falls only after an acknowledge;
- the row address moves only by single increments;
- the overrun flag never clears outside reset and rises only when a request was already pending.

Only the bench scenarios can show the exact interval length and its rounding, the tie between a tick and an acknowledge, the single count for a long acknowledge, and the wrap after 256 rows. The bench compares these against a cycle-by-cycle reference model.

// File: rtl/refresh_pkg.sv
package refresh_pkg;

    localparam longint unsigned NS_PER_S = 64'd1_000_000_000;

    // Clock cycles in one refresh interval, rounded to the nearest cycle.
    function automatic int unsigned interval_cycles(input longint unsigned clk_hz,
                                                    input longint unsigned period_ns);
        longint unsigned prod;
        prod = clk_hz * period_ns + NS_PER_S / 2;
        return 32'(prod / NS_PER_S);
    endfunction

    typedef struct packed {
        logic pending;
        logic overrun;
    } req_state_t;

endpackage

// File: rtl/tick_prescaler.sv
module tick_prescaler #(
    parameter int unsigned TICKS = 3750
) (
    input  logic clk,
    input  logic rst,
    output logic tick_o
);
    localparam int unsigned CW = (TICKS > 2) ? $clog2(TICKS) : 1;
    localparam logic [CW-1:0] LAST = CW'(TICKS - 1);

    logic [CW-1:0] cnt_q;

    assign tick_o = (cnt_q == LAST);

    always_ff @(posedge clk) begin
        if (rst)          cnt_q <= '0;
        else if (tick_o)  cnt_q <= '0;
        else              cnt_q <= cnt_q + 1'b1;
    end
endmodule

// File: rtl/req_latch.sv
module req_latch
    import refresh_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       set_i,
    input  logic       clr_i,
    output req_state_t state_o
);
    req_state_t st_q, st_d;

    always_comb begin
        st_d = st_q;
        if (set_i && st_q.pending && !clr_i) st_d.overrun = 1'b1;
        if (set_i)       st_d.pending = 1'b1;
        else if (clr_i)  st_d.pending = 1'b0;
    end

    always_ff @(posedge clk) begin
        if (rst) st_q <= '0;
        else     st_q <= st_d;
    end

    assign state_o = st_q;
endmodule

// File: rtl/row_counter.sv
module row_counter #(
    parameter int unsigned W = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         ack_i,
    output logic [W-1:0] row_o
);
    logic ack_q;
    logic [W-1:0] row_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            ack_q <= 1'b0;
            row_q <= '0;
        end else begin
            ack_q <= ack_i;
            if (ack_q && !ack_i) row_q <= row_q + 1'b1;
        end
    end

    assign row_o = row_q;
endmodule

// File: rtl/refresh_req_gen.sv
module refresh_req_gen
    import refresh_pkg::*;
#(
    parameter longint unsigned CLK_HZ    = 250_000_000,
    parameter longint unsigned PERIOD_NS = 15_000,
    parameter int unsigned     ROW_W     = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             refresh_ack_i,
    output logic             dma_req_o,
    output logic             refresh_o,
    output logic [ROW_W-1:0] row_addr_o,
    output logic             overrun_o
);
    localparam int unsigned TICKS = interval_cycles(CLK_HZ, PERIOD_NS);

    logic       tick;
    req_state_t rq;

    tick_prescaler #(.TICKS(TICKS)) u_presc (
        .clk(clk), .rst(rst), .tick_o(tick)
    );

    req_latch u_req (
        .clk(clk), .rst(rst), .set_i(tick), .clr_i(refresh_ack_i), .state_o(rq)
    );

    row_counter #(.W(ROW_W)) u_row (
        .clk(clk), .rst(rst), .ack_i(refresh_ack_i), .row_o(row_addr_o)
    );

    assign dma_req_o = rq.pending;
    assign overrun_o = rq.overrun;
    assign refresh_o = refresh_ack_i;
endmodule

// File: rtl/refresh_req_gen_chk.sv
module refresh_req_gen_chk #(
    parameter int unsigned ROW_W = 8
) (
    input logic             clk,
    input logic             rst,
    input logic             refresh_ack_i,
    input logic             dma_req_o,
    input logic             refresh_o,
    input logic [ROW_W-1:0] row_addr_o,
    input logic             overrun_o
);
    assert_refresh_mirror_R3: assert property (@(posedge clk) disable iff (rst)
        refresh_o == refresh_ack_i);

    assert_req_holds_R2: assert property (@(posedge clk) disable iff (rst)
        (dma_req_o && !refresh_ack_i) |=> dma_req_o);

    assert_req_drop_needs_ack_R2: assert property (@(posedge clk) disable iff (rst)
        $fell(dma_req_o) |-> $past(refresh_ack_i));

    assert_row_single_step_R4: assert property (@(posedge clk) disable iff (rst)
        !$stable(row_addr_o) |-> (row_addr_o == ROW_W'($past(row_addr_o) + 1'b1)));

    assert_overrun_sticky_R6: assert property (@(posedge clk) disable iff (rst)
        $past(overrun_o) |-> overrun_o);

    assert_overrun_cause_R6: assert property (@(posedge clk) disable iff (rst)
        $rose(overrun_o) |-> $past(dma_req_o));
endmodule

bind refresh_req_gen refresh_req_gen_chk #(.ROW_W(ROW_W)) u_chk (
    .clk(clk), .rst(rst), .refresh_ack_i(refresh_ack_i), .dma_req_o(dma_req_o),
    .refresh_o(refresh_o), .row_addr_o(row_addr_o), .overrun_o(overrun_o)
);

// File: tb/refresh_req_gen_tb_top.sv
module refresh_req_gen_tb_top;
    // 1.7 MHz x 15 us = 25.5 cycles, rounded to 26
    localparam int EXP_T = 26;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic ack = 1'b0;
    logic dreq, refr, ovr;
    logic [7:0] row;

    int total = 0;
    int bad = 0;

    int m_edges = 0;
    int m_row = 0;
    bit m_req = 0, m_ov = 0, m_prev_ack = 0;

    always #2 clk = ~clk;

    refresh_req_gen #(.CLK_HZ(1_700_000), .PERIOD_NS(15_000), .ROW_W(8)) dut_i (
        .clk(clk), .rst(rst), .refresh_ack_i(ack), .dma_req_o(dreq),
        .refresh_o(refr), .row_addr_o(row), .overrun_o(ovr)
    );

    task automatic check(input string tag, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d t=%0t", tag, act, exp, $time);
        end
    endtask

    task automatic step(input bit a);
        bit tick;
        ack = a;
        #1;
        check("R3 refresh", int'(refr), int'(a));
        m_edges++;
        tick = (m_edges % EXP_T) == 0;
        if (tick && m_req && !a) m_ov = 1;
        if (m_prev_ack && !a) m_row = (m_row + 1) % 256;
        if (tick) m_req = 1;
        else if (a) m_req = 0;
        m_prev_ack = a;
        @(posedge clk);
        @(negedge clk);
        check("R2 request", int'(dreq), int'(m_req));
        check("R4 row", int'(row), m_row);
        check("R6 overrun", int'(ovr), int'(m_ov));
    endtask

    task automatic do_reset();
        rst = 1'b1;
        ack = 1'b0;
        repeat (2) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        m_edges = 0; m_row = 0; m_req = 0; m_ov = 0; m_prev_ack = 0;
        check("R7 reset req", int'(dreq), 0);
        check("R7 reset row", int'(row), 0);
        check("R7 reset overrun", int'(ovr), 0);
    endtask

    initial begin
        #800000;
        total++;
        bad++;
        $display("FAIL watchdog actual=timeout expected=completion");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        int start;
        @(negedge clk);
        do_reset();

        // R1: request appears exactly EXP_T edges after reset release
        for (int i = 0; i < EXP_T - 1; i++) step(0);
        check("R1 before interval", int'(dreq), 0);
        step(0);
        check("R1 at interval", int'(dreq), 1);

        // R2/R4: ack clears request; long ack counts one row
        step(0);
        step(1);
        check("R2 cleared by ack", int'(dreq), 0);
        step(1); step(1);
        check("R4 no step while held", int'(row), 0);
        step(0);
        check("R4 single step", int'(row), 1);

        // R6: skip service across two intervals
        for (int i = 0; i < 2 * EXP_T; i++) step(0);
        check("R6 overrun set", int'(ovr), 1);
        step(1); step(0);
        check("R6 overrun sticky", int'(ovr), 1);

        // R2: tick coincident with ack keeps request
        while ((m_edges % EXP_T) != EXP_T - 1) step(0);
        step(1);
        check("R2 tick wins over ack", int'(dreq), 1);
        step(0);
        step(1);
        step(0);

        // R5: wrap of the row counter
        start = m_row;
        for (int i = 0; i < 300; i++) begin
            step(1);
            step(0);
        end
        check("R5 wrap", int'(row), (start + 300) % 256);

        // R7: reset mid-run
        step(1);
        do_reset();
        for (int i = 0; i < EXP_T; i++) step(0);
        check("R1 after reset", int'(dreq), 1);

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule